// File: doc/BRIEF.md
# Framed Serial Command Word Receiver

This block accepts command words over a three-wire serial link: an active-low select, a serial clock and a data line. All three pins are brought into a fast system clock domain through synchronizers. Edges of the serial clock and the select line are detected there. While a frame is open, each falling edge of the serial clock shifts one data bit into a 16-bit register, most significant bit first.

When the select line returns high, the block checks whether at least 16 bits arrived. If so, it hands the register contents to the decoder behind it as a parallel word, together with a single-cycle valid strobe. A shorter frame is thrown away. A longer frame keeps only its final 16 bits.

The most significant stage of the shift register drives a serial output. That output reproduces the input stream 16 clock falls later, so several receivers can be chained on one select line. In such a chain, each receiver acts on whatever its own register holds when the select line is released. The upper four bits of a word are a command field and the next ten are a data code. The lowest two bits must be zero; if either is set, a flag is raised alongside the word, which is still passed on.

Top module: `serial_word_rx`

## Requirements
- R1: After the asynchronous active-low clear, `word_valid` is 0, `word` is 0, `tail_err` is 0 and `sdo` is 0.
- R2: A frame opens on a falling edge of `cs_n`. Each serial clock fall inside it shifts `sdi` in, first bit into the most significant position. When `cs_n` rises after exactly 16 falls, `word` holds the 16 bits in arrival order and `word_valid` pulses once.
- R3: If `cs_n` rises after fewer than 16 serial clock falls, no `word_valid` pulse occurs and `word` keeps its previous value.
- R4: A frame with more than 16 falls produces one pulse, and `word` holds the last 16 bits received. The internal bit count stops at 16.
- R5: `sdo` equals the `sdi` bit sampled 16 in-frame serial clock falls earlier; before 16 such falls since clear, it shows 0. The shift register is not cleared between frames.
- R6: Operation is the same whether the serial clock rests high or low while `cs_n` is high.
- R7: Asserting the clear in mid-frame discards the partial word: no pulse follows the next `cs_n` rise, and `sdo` reads 0.
- R8: `tail_err` is loaded with each word and is 1 exactly when either of `word[1:0]` is 1. The word is delivered either way.
- R9: `word_valid` is never high in two consecutive system clocks, and `word` does not change in cycles without a pulse.
- R10: Serial clock edges while `cs_n` is high shift nothing: `sdo` and the next delivered word are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low clear |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, data sampled on its falling edge |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, input delayed by 16 serial clocks |
| word | output | 16 | Last complete word received |
| word_valid | output | 1 | One-cycle strobe marking a new word |
| tail_err | output | 1 | Set with a word whose two lowest bits are not both zero |

## Verification
The bench targets frame length at the 16-bit boundary from both sides. A receiver that counted off by one would forward a 15-bit frame or drop a 16-bit one. Long frames check that the kept bits are the last 16 and not the first, which an unsaturated or wrapping counter would get wrong. The delayed output is checked bit by bit across frame boundaries, which catches a register cleared at frame start or a tap at the wrong stage. A clear in mid-frame, clock toggling with select high, and both clock idle levels check that stray edges are neither counted nor shifted.

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
  parameter int WORD_W = 16,
  parameter int TAIL_W = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic [WORD_W-1:0] word,
  output logic              word_valid,
  output logic              tail_err
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [SYNC_N-1:0] cs_q, ck_q, di_q;
  logic              cs_d, ck_d, active;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= '0;
      ck_q <= '0;
      di_q <= '0;
      cs_d <= 1'b0;
      ck_d <= 1'b0;
    end else begin
      cs_q <= {cs_q[SYNC_N-2:0], cs_n};
      ck_q <= {ck_q[SYNC_N-2:0], sclk};
      di_q <= {di_q[SYNC_N-2:0], sdi};
      cs_d <= cs_q[SYNC_N-1];
      ck_d <= ck_q[SYNC_N-1];
    end

  wire cs_s     = cs_q[SYNC_N-1];
  wire cs_fall  = cs_d & ~cs_s;
  wire cs_rise  = ~cs_d & cs_s;
  wire shift_en = active & ~cs_s & ck_d & ~ck_q[SYNC_N-1];
  wire load     = active & cs_rise & (bit_cnt == FULL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active  <= 1'b0;
      bit_cnt <= '0;
      sh      <= '0;
    end else begin
      if (cs_fall) active <= 1'b1;
      else if (cs_rise) active <= 1'b0;
      if (cs_fall) bit_cnt <= '0;
      else if (shift_en && bit_cnt != FULL) bit_cnt <= bit_cnt + 1'b1;
      if (shift_en) sh <= {sh[WORD_W-2:0], di_q[SYNC_N-1]};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word_valid <= 1'b0;
      word       <= '0;
      tail_err   <= 1'b0;
    end else begin
      word_valid <= load;
      if (load) begin
        word     <= sh;
        tail_err <= |sh[TAIL_W-1:0];
      end
    end

  assign sdo = sh[WORD_W-1];
endmodule

module serial_word_rx_chk #(
  parameter int WORD_W = 16,
  parameter int TAIL_W = 2,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdo,
  input logic [WORD_W-1:0] word,
  input logic              word_valid,
  input logic              tail_err,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              shift_en
);
  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word));
  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W));
  // R8
  tail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (tail_err == (|word[TAIL_W-1:0])));
  // R10
  sdo_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(shift_en) |-> $stable(sdo));
endmodule

bind serial_word_rx serial_word_rx_chk #(
  .WORD_W(WORD_W), .TAIL_W(TAIL_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .word(word),
  .word_valid(word_valid), .tail_err(tail_err),
  .bit_cnt(bit_cnt), .shift_en(shift_en)
);

// File: tb/serial_word_rx_bench.sv
module serial_word_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, word_valid, tail_err;
  logic [15:0] word;

  int n_cmp = 0, n_bad = 0, vcnt = 0, pulse_bad = 0;
  logic prev_v = 1'b0;
  logic [15:0] cap_word = '0, hist = '0;
  logic cap_err = 1'b0;

  serial_word_rx u_serial_word_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .word(word), .word_valid(word_valid), .tail_err(tail_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      vcnt++;
      cap_word = word;
      cap_err = tail_err;
      if (prev_v) pulse_bad++;
    end
    prev_v = word_valid;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic exp_tail(input logic [15:0] w);
    return |w[1:0];
  endfunction

  task automatic send_frame(input logic [63:0] bits, input int n, input bit idle_hi,
                            input int abort_at, input string req);
    int v0;
    bit alive = 1'b1;
    sclk = idle_hi;
    tick(HALF);
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = bits[n-1-i];
      if (i == abort_at) begin
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(3);
        alive = 1'b0;
        hist = '0;
        check("R7 sdo after clear", sdo, 1'b0);
      end
      sclk = 1'b1;
      sdi = b;
      tick(HALF);
      sclk = 1'b0;
      if (alive) hist = {hist[14:0], b};
      tick(HALF);
      check("R5 sdo", sdo, hist[15]);
    end
    if (idle_hi) sclk = 1'b1;
    tick(HALF);
    v0 = vcnt;
    cs_n = 1'b1;
    tick(12);
    if (alive && n >= 16) begin
      check({req, " pulse"}, vcnt - v0, 1);
      check({req, " word"}, cap_word, bits[15:0]);
      check("R8 tail_err", cap_err, exp_tail(bits[15:0]));
    end else begin
      check({req, " no pulse"}, vcnt - v0, 0);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd4321));
    tick(3);
    // R1
    check("R1 word_valid", word_valid, 0);
    check("R1 word", word, 0);
    check("R1 tail_err", tail_err, 0);
    check("R1 sdo", sdo, 0);
    rst_n = 1'b1;
    tick(4);

    send_frame(64'hA5C0, 16, 1'b0, -1, "R2");
    held = word;
    send_frame(64'h3ABD, 16, 1'b0, -1, "R8");
    held = word;
    send_frame(64'h55, 7, 1'b0, -1, "R3");
    check("R3 word kept", word, held);
    send_frame(64'h0, 15, 1'b1, -1, "R3");
    send_frame(64'hC3_F0F0, 24, 1'b0, -1, "R4");
    send_frame(64'h1234_5678_9ABC, 48, 1'b1, -1, "R4");
    send_frame(64'h8E04, 16, 1'b1, -1, "R6");
    send_frame(64'h7FFF, 16, 1'b0, 9, "R7");
    check("R7 word cleared", word, 0);

    // R10: clock toggles with select high
    sdi = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b1; tick(HALF);
      sclk = 1'b0; tick(HALF);
    end
    check("R10 sdo idle", sdo, hist[15]);
    send_frame(64'h0F0C, 16, 1'b0, -1, "R10");

    for (int r = 0; r < 40; r++) begin
      logic [63:0] bits;
      int n;
      bits = {$urandom, $urandom};
      case ($urandom % 3)
        0: n = 1 + ($urandom % 15);
        1: n = 16;
        default: n = 17 + ($urandom % 40);
      endcase
      send_frame(bits, n, 1'($urandom), -1, n > 16 ? "R4" : (n == 16 ? "R2" : "R3"));
    end

    // R9
    check("R9 pulse width", pulse_bad, 0);
    summary();
    $finish;
  end
endmodule